// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the protocol layer of a two-wire serial memory slave for a 512-byte array. It does not see the bus wires. A front end gives it single-cycle strobes: START, STOP, the falling SCL edge, and each data bit sampled on the rising SCL edge. The block returns one pin that tells the front end to pull SDA low. On top of these strobes it matches the control byte, sends acknowledges, and keeps a 9-bit address pointer. It carries out random and page writes, and current-address, random and sequential reads.

Reads use a synchronous memory port. The block pulses a read request, and the data is taken one cycle later. Written bytes leave through a valid/ready stream that carries the target address and the data. The consumer is a page buffer or a program sequencer. It may hold ready low for as long as it needs. While valid is high and ready is low, the address and data do not change. A data byte that completes while the previous byte is still waiting is not acknowledged and is dropped, so the bus master sees the back-pressure as a missing acknowledge.

A STOP that ends a write transaction with at least one accepted data byte produces a pulse that starts programming. While the programming input is high, the block acknowledges nothing.

Top module: `eep_slave_ctrl`

## Requirements
- R1: The control byte is sent MSB first. Bits 7:4 must be 1010. Bit 3 must equal chip_sel_i[1] and bit 2 must equal chip_sel_i[0]. Bit 0 selects the direction: 0 is write, 1 is read. A matching control byte is acknowledged.
- R2: A control byte whose device code or chip bits do not match sends the block to idle. It then does not drive SDA in any slot until the next START.
- R3: Bit 1 of every accepted control byte becomes pointer bit 8, which selects the upper or lower 256-byte half. Pointer bits 7:0 keep their value, so a read control byte alone reads from the current address.
- R4: After a write control byte, the next byte loads pointer bits 7:0. Every later byte is data. Each data byte is offered on the write stream together with the pointer value at the moment it arrived.
- R5: An acknowledge drives sda_low_o from the scl_fall_i that follows the 8th bit strobe until the scl_fall_i that follows the 9th bit strobe. While the master sends bits 1 to 7 of a byte, SDA is released.
- R6: When busy_i is high as a byte completes, the block does not acknowledge that byte. If the byte was a control byte or a word address byte, the block also returns to idle.
- R7: After each accepted data byte, pointer bits 2:0 increment and wrap within an 8-byte page. Bits 8:3 do not change.
- R8: In a read, bytes go out MSB first, and sda_low_o is the inverse of each bit. A master acknowledge (0 in the 9th slot) advances the whole 9-bit pointer, which wraps from 0x1FF to 0x000, and the next byte is fetched. A master non-acknowledge releases SDA, sends the block to idle, and leaves the pointer unchanged.
- R9: prog_start_o pulses for one cycle, one cycle after a STOP that ends a write transaction in which at least one data byte was accepted. No other STOP produces the pulse.
- R10: While wr_valid_o is high and wr_ready_i is low, wr_addr_o and wr_data_o hold their values. A data byte that completes while wr_valid_o is still high is not acknowledged and is discarded, and the pointer does not move.
- R11: After reset, sda_low_o, wr_valid_o, prog_start_o and mem_rd_o are low.
- R12: A read fetch pulses mem_rd_o for one cycle with mem_addr_o set to the pointer. mem_rdata_i is taken on the following cycle. A repeated START after the word address turns a write setup into a random read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START seen on the bus (one cycle) |
| stop_i | input | 1 | STOP seen on the bus (one cycle) |
| scl_fall_i | input | 1 | Falling SCL edge strobe; SDA drive is updated here |
| bit_vld_i | input | 1 | Rising SCL edge strobe; bit_i is valid |
| bit_i | input | 1 | Sampled SDA level |
| chip_sel_i | input | 2 | Hard-wired chip address |
| busy_i | input | 1 | Programming in progress |
| sda_low_o | output | 1 | Pull SDA low |
| mem_addr_o | output | 9 | Memory read address (pointer) |
| mem_rd_o | output | 1 | Memory read request |
| mem_rdata_i | input | 8 | Memory read data, one cycle after request |
| wr_valid_o | output | 1 | Write byte valid |
| wr_ready_i | input | 1 | Write consumer ready |
| wr_addr_o | output | 9 | Write byte address |
| wr_data_o | output | 8 | Write byte data |
| prog_start_o | output | 1 | Start internal programming (pulse) |

## Verification
The hardest case to reach is a data byte that arrives while the write slot is still occupied. The bench creates it by holding wr_ready_i low across two data bytes of one transaction. It then checks that the second byte is not acknowledged, that the held address and data are unchanged, and that the byte sent after ready returns lands at the next address. A second hard case is the pointer wrapping, both inside a page and across the whole array. The bench reaches the array wrap with a sequential read of 520 bytes starting at 0x000, and the page wrap with a page write that starts two bytes below a page boundary.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } eep_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/eep_bit_shift.sv
module eep_bit_shift #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          bit_vld_i,
  input  logic          bit_i,
  output logic [CW-1:0] cnt_o,
  output logic [W-1:0]  byte_o,
  output logic          done_o,
  output logic          slot_end_o
);
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (bit_vld_i) begin
      cnt_q <= (cnt_q == CW'(W)) ? '0 : CW'(cnt_q + 1'b1);
      sh_q  <= {sh_q[W-2:0], bit_i};
    end
  end

  assign cnt_o      = cnt_q;
  assign byte_o     = {sh_q[W-2:0], bit_i};
  assign done_o     = bit_vld_i && !clr_i && (cnt_q == CW'(W - 1));
  assign slot_end_o = bit_vld_i && !clr_i && (cnt_q == CW'(W));

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(W));
endmodule

// File: rtl/eep_ptr.sv
module eep_ptr #(
  parameter int AW = 9,
  parameter int PB = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          blk_we_i,
  input  logic          blk_i,
  input  logic          lo_we_i,
  input  logic [AW-2:0] lo_i,
  input  logic          page_inc_i,
  input  logic          seq_inc_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else begin
      if (blk_we_i)   ptr_q[AW-1]   <= blk_i;
      if (lo_we_i)    ptr_q[AW-2:0] <= lo_i;
      if (page_inc_i) ptr_q[PB-1:0] <= PB'(ptr_q[PB-1:0] + 1'b1);
      if (seq_inc_i)  ptr_q         <= AW'(ptr_q + 1'b1);
    end
  end

  assign ptr_o = ptr_q;

  // R7
  page_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_inc_i |=> (ptr_q[AW-1:PB] == $past(ptr_q[AW-1:PB])) &&
                   (ptr_q[PB-1:0] == PB'($past(ptr_q[PB-1:0]) + 1'b1)));

  // R8
  seq_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_inc_i && (ptr_q == '1)) |=> (ptr_q == '0));
endmodule

// File: rtl/eep_wr_slot.sv
module eep_wr_slot #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      data_o  <= data_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o && $stable(addr_o) && $stable(data_o));
endmodule

// File: rtl/eep_slave_ctrl.sv
module eep_slave_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int PAGE_BITS = 3,
  parameter int CHIP_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_fall_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic [CHIP_W-1:0] chip_sel_i,
  input  logic              busy_i,
  output logic              sda_low_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              prog_start_o
);
  localparam int CW = $clog2(BYTE_W + 1);

  eep_state_e        st_q, st_d, nxt_q, nxt_d;
  logic              ack_q, ack_d, wrote_q, wrote_d;
  logic              blk_we, lo_we, page_inc, seq_inc, slot_ld, rd_req;
  logic              rd_dly_q, sda_q, prog_q;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] byte_now, tx_q;
  logic              done, slot_end;
  logic [ADDR_W-1:0] ptr;
  logic              hit, rw, blk;

  eep_bit_shift #(.W(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_i),
    .bit_vld_i  (bit_vld_i),
    .bit_i      (bit_i),
    .cnt_o      (cnt),
    .byte_o     (byte_now),
    .done_o     (done),
    .slot_end_o (slot_end)
  );

  eep_ptr #(.AW(ADDR_W), .PB(PAGE_BITS)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .blk_we_i   (blk_we),
    .blk_i      (blk),
    .lo_we_i    (lo_we),
    .lo_i       (byte_now[ADDR_W-2:0]),
    .page_inc_i (page_inc),
    .seq_inc_i  (seq_inc),
    .ptr_o      (ptr)
  );

  eep_wr_slot #(.AW(ADDR_W), .DW(BYTE_W)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (slot_ld),
    .addr_i  (ptr),
    .data_i  (byte_now),
    .ready_i (wr_ready_i),
    .valid_o (wr_valid_o),
    .addr_o  (wr_addr_o),
    .data_o  (wr_data_o)
  );

  // control byte fields: code[7:4], chip[3:2], block bit[1], direction[0]
  assign hit = (byte_now[7:4] == DEV_CODE) && (byte_now[1+CHIP_W:2] == chip_sel_i);
  assign blk = byte_now[1];
  assign rw  = byte_now[0];

  always_comb begin
    st_d     = st_q;
    nxt_d    = nxt_q;
    ack_d    = ack_q;
    wrote_d  = wrote_q;
    blk_we   = 1'b0;
    lo_we    = 1'b0;
    page_inc = 1'b0;
    seq_inc  = 1'b0;
    slot_ld  = 1'b0;
    rd_req   = 1'b0;
    if (start_i) begin
      st_d    = ST_CTRL;
      ack_d   = 1'b0;
      wrote_d = 1'b0;
    end else if (stop_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_CTRL: begin
          if (done) begin
            if (hit && !busy_i) begin
              ack_d  = 1'b1;
              blk_we = 1'b1;
              rd_req = rw;
              nxt_d  = rw ? ST_RDATA : ST_WADDR;
            end else begin
              ack_d = 1'b0;
              st_d  = ST_IDLE;
            end
          end else if (slot_end) begin
            st_d = nxt_q;
          end
        end
        ST_WADDR: begin
          if (done) begin
            if (!busy_i) begin
              ack_d = 1'b1;
              lo_we = 1'b1;
              nxt_d = ST_WDATA;
            end else begin
              ack_d = 1'b0;
              st_d  = ST_IDLE;
            end
          end else if (slot_end) begin
            st_d = nxt_q;
          end
        end
        ST_WDATA: begin
          if (done) begin
            if (!busy_i && !wr_valid_o) begin
              ack_d    = 1'b1;
              slot_ld  = 1'b1;
              page_inc = 1'b1;
              wrote_d  = 1'b1;
            end else begin
              ack_d = 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (slot_end) begin
            if (!bit_i) begin
              seq_inc = 1'b1;
              rd_req  = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      ack_q    <= 1'b0;
      wrote_q  <= 1'b0;
      mem_rd_o <= 1'b0;
      rd_dly_q <= 1'b0;
      prog_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      nxt_q    <= nxt_d;
      ack_q    <= ack_d;
      wrote_q  <= wrote_d;
      mem_rd_o <= rd_req;
      rd_dly_q <= mem_rd_o;
      prog_q   <= stop_i && !start_i && (st_q == ST_WDATA) && wrote_q;
    end
  end

  // SDA drive: updated only on falling SCL strobes, cleared by START/STOP
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b0;
      tx_q  <= '0;
    end else if (start_i || stop_i) begin
      sda_q <= 1'b0;
    end else if (rd_dly_q) begin
      tx_q <= mem_rdata_i;
    end else if (scl_fall_i) begin
      case (st_q)
        ST_RDATA: begin
          if (cnt < CW'(BYTE_W)) begin
            sda_q <= ~tx_q[BYTE_W-1];
            tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
          end else begin
            sda_q <= 1'b0;
          end
        end
        ST_CTRL, ST_WADDR, ST_WDATA: sda_q <= (cnt == CW'(BYTE_W)) && ack_q;
        default: sda_q <= 1'b0;
      endcase
    end
  end

  assign sda_low_o    = sda_q;
  assign mem_addr_o   = ptr;
  assign prog_start_o = prog_q;

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_low_o);

  // R5
  recv_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q inside {ST_CTRL, ST_WADDR, ST_WDATA}) && (cnt >= CW'(1)) &&
     (cnt <= CW'(BYTE_W - 1))) |-> !sda_low_o);

  // R6
  busy_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && busy_i && !start_i && !stop_i &&
     (st_q inside {ST_CTRL, ST_WADDR, ST_WDATA})) |=> !ack_q);

  // R9
  prog_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> $past(stop_i));

  // R12
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
endmodule

// File: tb/eep_slave_ctrl_tb.sv
module eep_slave_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0, scl_fall_i = 1'b0;
  logic       bit_vld_i = 1'b0, bit_i = 1'b0;
  logic [1:0] chip_sel_i = 2'b10;
  logic       busy_i = 1'b0;
  logic       sda_low_o;
  logic [8:0] mem_addr_o;
  logic       mem_rd_o;
  logic [7:0] mem_rdata_i;
  logic       wr_valid_o;
  logic       wr_ready_i = 1'b1;
  logic [8:0] wr_addr_o;
  logic [7:0] wr_data_o;
  logic       prog_start_o;

  int n_tests = 0, n_fail = 0, prog_cnt = 0, log_n = 0;
  bit drv_seen = 0, finished = 0;
  logic [7:0] mem [0:511];
  logic [8:0] log_a [0:63];
  logic [7:0] log_d [0:63];

  always #5 clk_i = ~clk_i;

  eep_slave_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .scl_fall_i(scl_fall_i), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .chip_sel_i(chip_sel_i), .busy_i(busy_i), .sda_low_o(sda_low_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_rdata_i(mem_rdata_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .prog_start_o(prog_start_o)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // memory model and write consumer
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 512; i++) mem[i] <= pat(i);
      mem_rdata_i <= '0;
    end else begin
      if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
      if (wr_valid_o && wr_ready_i) begin
        mem[wr_addr_o] <= wr_data_o;
        log_a[log_n]   <= wr_addr_o;
        log_d[log_n]   <= wr_data_o;
        log_n          <= log_n + 1;
      end
    end
    if (prog_start_o) prog_cnt <= prog_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bit_xfer(input logic b, output logic line);
    @(negedge clk_i) scl_fall_i = 1'b1;
    @(negedge clk_i) scl_fall_i = 1'b0;
    tick(2);
    if (sda_low_o) drv_seen = 1;
    line = b & ~sda_low_o;
    bit_i = line;
    bit_vld_i = 1'b1;
    @(negedge clk_i) bit_vld_i = 1'b0;
    tick(3);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic ln;
    for (int i = 7; i >= 0; i--) bit_xfer(v[i], ln);
    bit_xfer(1'b1, ln);
    ack = !ln;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic ln;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, ln);
      v[i] = ln;
    end
    bit_xfer(!mack, ln);
  endtask

  task automatic do_start();
    @(negedge clk_i) scl_fall_i = 1'b1;
    @(negedge clk_i) scl_fall_i = 1'b0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    tick(2);
  endtask

  task automatic do_stop();
    @(negedge clk_i) scl_fall_i = 1'b1;
    @(negedge clk_i) scl_fall_i = 1'b0;
    @(negedge clk_i) stop_i = 1'b1;
    @(negedge clk_i) stop_i = 1'b0;
    tick(3);
  endtask

  function automatic logic [7:0] ctrl(input logic a0, input logic rd);
    return {4'b1010, chip_sel_i, a0, rd};
  endfunction

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack, exp;
    logic [7:0] v;
    int p0;
    tick(5);
    // R11 reset state
    chk(sda_low_o == 0 && wr_valid_o == 0 && prog_start_o == 0 && mem_rd_o == 0,
        "R11", {sda_low_o, wr_valid_o, prog_start_o, mem_rd_o}, 0);
    rst_ni = 1'b1;
    tick(3);

    // R1/R2 sweep of all control bytes
    for (int c = 0; c < 256; c++) begin
      do_start();
      drv_seen = 0;
      wr_byte(8'(c), ack);
      exp = (c[7:4] == 4'hA) && (c[3:2] == chip_sel_i);
      chk(ack == exp, "R1", ack, exp);
      if (!exp) begin
        wr_byte(8'h00, ack);
        chk(!drv_seen, "R2", drv_seen, 0);
      end
      do_stop();
    end
    chip_sel_i = 2'b01;
    for (int c = 0; c < 4; c++) begin
      do_start();
      wr_byte({4'hA, 2'(c), 2'b00}, ack);
      chk(ack == (c == 1), "R1", ack, c == 1);
      do_stop();
    end
    chip_sel_i = 2'b10;
    chk(prog_cnt == 0, "R9", prog_cnt, 0);

    // R8 sequential read across the whole array with wrap
    do_start(); wr_byte(ctrl(1'b0, 1'b0), ack); wr_byte(8'h00, ack);
    do_start(); wr_byte(ctrl(1'b0, 1'b1), ack);
    chk(ack, "R12", ack, 1);
    for (int k = 0; k < 520; k++) begin
      rd_byte(k != 519, v);
      chk(v == mem[k & 511], "R8", v, mem[k & 511]);
    end
    chk(sda_low_o == 0, "R8", sda_low_o, 0);
    do_stop();

    // R12/R3 random read with block bit replaced by read control byte
    do_start(); wr_byte(ctrl(1'b1, 1'b0), ack); wr_byte(8'h20, ack);
    do_start(); wr_byte(ctrl(1'b0, 1'b1), ack);
    rd_byte(1'b0, v);
    chk(v == mem[9'h020], "R12", v, mem[9'h020]);
    do_stop();
    do_start(); wr_byte(ctrl(1'b1, 1'b1), ack);
    rd_byte(1'b0, v);
    chk(v == mem[9'h120], "R3", v, mem[9'h120]);
    do_stop();

    // R4/R5/R7/R3 page write wrapping inside the page, upper half
    p0 = log_n;
    do_start(); wr_byte(ctrl(1'b1, 1'b0), ack);
    chk(ack, "R5", ack, 1);
    wr_byte(8'hF6, ack);
    chk(ack, "R4", ack, 1);
    for (int k = 0; k < 4; k++) begin
      wr_byte(8'h11 + 8'(k), ack);
      chk(ack, "R5", ack, 1);
    end
    do_stop();
    chk(prog_cnt == 1, "R9", prog_cnt, 1);
    chk(log_n - p0 == 4, "R4", log_n - p0, 4);
    for (int k = 0; k < 4; k++) begin
      logic [8:0] ea;
      ea = {6'b111110, 3'(6 + k)};
      chk(log_a[p0+k] == ea, "R7", log_a[p0+k], ea);
      chk(log_d[p0+k] == 8'h11 + 8'(k), "R4", log_d[p0+k], 8'h11 + k);
    end

    // R10 back-pressure
    wr_ready_i = 1'b0;
    p0 = log_n;
    do_start(); wr_byte(ctrl(1'b0, 1'b0), ack); wr_byte(8'h40, ack);
    wr_byte(8'hA1, ack);
    chk(ack, "R10", ack, 1);
    wr_byte(8'hB2, ack);
    chk(!ack, "R10", ack, 0);
    chk(wr_valid_o && wr_addr_o == 9'h040 && wr_data_o == 8'hA1, "R10",
        {wr_valid_o, wr_addr_o, wr_data_o}, {1'b1, 9'h040, 8'hA1});
    wr_ready_i = 1'b1;
    tick(2);
    wr_byte(8'hC3, ack);
    chk(ack, "R10", ack, 1);
    do_stop();
    chk(log_n - p0 == 2, "R10", log_n - p0, 2);
    chk(log_a[p0+1] == 9'h041 && log_d[p0+1] == 8'hC3, "R10", log_a[p0+1], 9'h041);
    chk(prog_cnt == 2, "R9", prog_cnt, 2);

    // R6 busy: control byte refused, later bytes not driven
    busy_i = 1'b1;
    do_start(); drv_seen = 0;
    wr_byte(ctrl(1'b0, 1'b0), ack);
    chk(!ack, "R6", ack, 0);
    wr_byte(8'h00, ack);
    chk(!drv_seen, "R6", drv_seen, 0);
    do_stop();
    busy_i = 1'b0;
    do_start(); wr_byte(ctrl(1'b0, 1'b0), ack);
    busy_i = 1'b1;
    wr_byte(8'h55, ack);
    chk(!ack, "R6", ack, 0);
    busy_i = 1'b0;
    do_stop();
    chk(prog_cnt == 2, "R9", prog_cnt, 2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule